// File: doc/BRIEF.md
# Capture Calibration Source Controller

This block is the debug control word for a high-resolution capture input path. A 32-bit register holds a handful of fields, and these fields decide which signal drives the capture input. The candidates are one of 128 external inputs picked by an index, a bit that software writes, or one of two internally generated square waves. The second square wave is the first one moved later by half a clock period. The delay line can use the two waves for linearity checks.

The block also shapes the delay-line reset pulse that follows each capture. Software can place that pulse either half a clock or one and a half clocks after the capture. A small state machine can flip the polarity of the capture input after every edge it sees, so that each edge reaches the delay line as a rising edge. A disable bit passes the input through unchanged instead. A four-bit code selects one of six observation buses, which is returned on a readback port.

When software changes the source or the software bit, the capture input may show an edge that was never really captured. No logic suppresses this edge.

Top module: `capcal_src_ctrl`

## Requirements
- R1: With calibration select (bits 5:4) at 00 and the pass-through bit (bit 0) at 1, `cap_in` equals `ext_in[ext_sel]` for every index 0 to 127.
- R2: With calibration select at 01 and bit 0 at 1, `cap_in` equals the software input bit (bit 2).
- R3: With calibration select at 10 and bit 0 at 1, `cap_in` is a square wave that stays high for 8 clocks and then low for 8 clocks. It changes only at rising clock edges.
- R4: With calibration select at 11 and bit 0 at 1, `cap_in` is the same 8-high, 8-low wave, but it changes only at falling clock edges, half a period after the R3 wave.
- R5: With the reset-timing bit (bit 1) at 0, a `cap_evt` strobe sampled at rising edge P0 drives `dl_reset` high from the falling edge after P0 until the falling edge after P1. This is a pulse of one clock.
- R6: With bit 1 at 1, the same pulse comes one clock later, from the falling edge after P1 until the falling edge after P2.
- R7: With bit 0 at 0, each change of the selected source, whether rising or falling, drives `cap_in` high at once. `cap_in` then returns low at the next rising clock edge, as long as the source does not change again.
- R8: With bit 0 at 1, no inversion takes place. A source held high keeps `cap_in` high.
- R9: Observe select (bits 11:8) maps to the readback port as follows: 1000 gives `hr_out1`, 1001 gives `hr_out2`, 1010 gives `dl1_obs1`, 1011 gives `dl2_obs1`, 1100 gives `dl1_obs2` and 1101 gives `dl2_obs2`.
- R10: Every other observe select code drives `obs_data` to zero.
- R11: A write stores bits 0, 1, 2, 5:4 and 11:8 of `wr_data`. The write takes effect at the next rising edge. `rd_data` returns the stored fields at the same positions, and all other bits read as zero.
- R12: After reset, every field reads zero and `dl_reset` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hr_clk | input | 1 | High-resolution clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to be written |
| rd_data | output | 32 | Control word readback |
| ext_in | input | 128 | External capture candidates |
| ext_sel | input | 7 | Index of the external candidate |
| cap_evt | input | 1 | One-cycle capture strobe from the capture logic |
| hr_out1 | input | 16 | High-resolution result 1 |
| hr_out2 | input | 16 | High-resolution result 2 |
| dl1_obs1 | input | 16 | Delay line 1 observation 1 |
| dl2_obs1 | input | 16 | Delay line 2 observation 1 |
| dl1_obs2 | input | 16 | Delay line 1 observation 2 |
| dl2_obs2 | input | 16 | Delay line 2 observation 2 |
| cap_in | output | 1 | Capture input driven into the delay line |
| dl_reset | output | 1 | Delay-line reset pulse |
| obs_data | output | 16 | Selected observation bus |

## Verification
The hardest behaviour to reach from the ports is the placement of edges within a clock period. The two calibration waves differ only in whether they move at the rising or the falling clock edge, and the two reset timings differ by exactly one period.

The bench samples `cap_in` and `dl_reset` twice per cycle, once just after the rising edge and once just after the falling edge. It checks which half of the cycle each transition falls in and measures the run lengths between transitions.

To exercise the inversion state machine, the bench toggles the selected external input in the middle of a cycle. It then checks that `cap_in` shows a pulse that lasts until the next rising edge, for both directions of source edge.

// File: rtl/capcal_pkg.sv
package capcal_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SRC_EXT   = 2'b00,
    SRC_SW    = 2'b01,
    SRC_WAVE  = 2'b10,
    SRC_SHIFT = 2'b11
  } cal_src_e;

  typedef enum logic [3:0] {
    OBS_HR1   = 4'b1000,
    OBS_HR2   = 4'b1001,
    OBS_D1O1  = 4'b1010,
    OBS_D2O1  = 4'b1011,
    OBS_D1O2  = 4'b1100,
    OBS_D2O2  = 4'b1101
  } obs_code_e;

  typedef struct packed {
    logic [3:0] obs_sel;
    cal_src_e   cal_sel;
    logic       sw_bit;
    logic       late_rst;
    logic       pass_thru;
  } cfg_t;

  function automatic cfg_t cfg_unpack(input logic [REG_W-1:0] w);
    cfg_t c;
    c.pass_thru = w[0];
    c.late_rst  = w[1];
    c.sw_bit    = w[2];
    c.cal_sel   = cal_src_e'(w[5:4]);
    c.obs_sel   = w[11:8];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_pack(input cfg_t c);
    logic [REG_W-1:0] w;
    w       = '0;
    w[0]    = c.pass_thru;
    w[1]    = c.late_rst;
    w[2]    = c.sw_bit;
    w[5:4]  = c.cal_sel;
    w[11:8] = c.obs_sel;
    return w;
  endfunction
endpackage

// File: rtl/capcal_cfg_reg.sv
module capcal_cfg_reg
  import capcal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cfg_t             cfg,
  output logic [REG_W-1:0] rd_data
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = cfg_unpack(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg     = cfg_q;
  assign rd_data = cfg_pack(cfg_q);
endmodule

// File: rtl/capcal_wave_gen.sv
module capcal_wave_gen #(
  parameter int HALF_CYC = 8,
  localparam int CNT_W   = $clog2(2 * HALF_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave,
  output logic wave_late
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             late_q;

  always_comb begin
    if (cnt_q == CNT_W'(2 * HALF_CYC - 1)) cnt_d = '0;
    else                                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign wave = (cnt_q < CNT_W'(HALF_CYC));

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) late_q <= 1'b0;
    else        late_q <= wave;
  end

  assign wave_late = late_q;
endmodule

// File: rtl/capcal_rst_timer.sv
module capcal_rst_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_evt,
  input  logic late_rst,
  output logic dl_reset
);
  logic evt_q;
  logic half_q;
  logic full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= cap_evt;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      half_q <= evt_q;
      full_q <= half_q;
    end
  end

  assign dl_reset = late_rst ? full_q : half_q;
endmodule

// File: rtl/capcal_inv_fsm.sv
module capcal_inv_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic inv_en,
  input  logic src,
  output logic dout
);
  logic inv_q, inv_d;
  logic flip_en;

  assign flip_en = inv_en && (src ^ inv_q);

  always_comb begin
    inv_d = inv_q;
    if (!inv_en)      inv_d = 1'b0;
    else if (flip_en) inv_d = ~inv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_q <= 1'b0;
    else        inv_q <= inv_d;
  end

  assign dout = inv_en ? (src ^ inv_q) : src;
endmodule

// File: rtl/capcal_src_ctrl.sv
module capcal_src_ctrl
  import capcal_pkg::*;
#(
  parameter int N_IN     = 128,
  parameter int SEL_W    = $clog2(N_IN),
  parameter int OBS_W    = 16,
  parameter int HALF_CYC = 8
) (
  input  logic             hr_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [N_IN-1:0]  ext_in,
  input  logic [SEL_W-1:0] ext_sel,
  input  logic             cap_evt,
  input  logic [OBS_W-1:0] hr_out1,
  input  logic [OBS_W-1:0] hr_out2,
  input  logic [OBS_W-1:0] dl1_obs1,
  input  logic [OBS_W-1:0] dl2_obs1,
  input  logic [OBS_W-1:0] dl1_obs2,
  input  logic [OBS_W-1:0] dl2_obs2,
  output logic             cap_in,
  output logic             dl_reset,
  output logic [OBS_W-1:0] obs_data
);
  logic [1:0] sync_q;
  logic       rst_s_n;
  cfg_t       cfg;
  logic       wave, wave_late;
  logic       src;

  always_ff @(posedge hr_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s_n = sync_q[1];

  capcal_cfg_reg u_reg (
    .clk     (hr_clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg     (cfg),
    .rd_data (rd_data)
  );

  capcal_wave_gen #(.HALF_CYC(HALF_CYC)) u_wave (
    .clk       (hr_clk),
    .rst_n     (rst_s_n),
    .wave      (wave),
    .wave_late (wave_late)
  );

  always_comb begin
    unique case (cfg.cal_sel)
      SRC_EXT:   src = ext_in[ext_sel];
      SRC_SW:    src = cfg.sw_bit;
      SRC_WAVE:  src = wave;
      SRC_SHIFT: src = wave_late;
      default:   src = 1'b0;
    endcase
  end

  capcal_inv_fsm u_inv (
    .clk    (hr_clk),
    .rst_n  (rst_s_n),
    .inv_en (~cfg.pass_thru),
    .src    (src),
    .dout   (cap_in)
  );

  capcal_rst_timer u_rst (
    .clk      (hr_clk),
    .rst_n    (rst_s_n),
    .cap_evt  (cap_evt),
    .late_rst (cfg.late_rst),
    .dl_reset (dl_reset)
  );

  always_comb begin
    case (cfg.obs_sel)
      OBS_HR1:  obs_data = hr_out1;
      OBS_HR2:  obs_data = hr_out2;
      OBS_D1O1: obs_data = dl1_obs1;
      OBS_D2O1: obs_data = dl2_obs1;
      OBS_D1O2: obs_data = dl1_obs2;
      OBS_D2O2: obs_data = dl2_obs2;
      default:  obs_data = '0;
    endcase
  end
endmodule

// File: rtl/capcal_src_ctrl_chk.sv
module capcal_src_ctrl_chk #(
  parameter int N_IN  = 128,
  parameter int SEL_W = 7,
  parameter int OBS_W = 16
) (
  input logic             hr_clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             cap_evt,
  input logic [OBS_W-1:0] hr_out1,
  input logic             cap_in,
  input logic             dl_reset,
  input logic [OBS_W-1:0] obs_data
);
  logic [1:0] since;

  always_ff @(posedge hr_clk or negedge rst_n) begin
    if (!rst_n)          since <= 2'd0;
    else if (since != 3) since <= since + 2'd1;
  end

  p_write_readback_r11: assert property (@(posedge hr_clk) disable iff (!rst_n)
    (since == 3 && wr_en) |=> rd_data == ($past(wr_data) & 32'h0000_0F37));

  p_obs_zero_r10: assert property (@(posedge hr_clk) disable iff (!rst_n)
    (rd_data[11:8] < 4'd8 || rd_data[11:8] > 4'd13) |-> obs_data == '0);

  p_obs_hr1_r9: assert property (@(posedge hr_clk) disable iff (!rst_n)
    (rd_data[11:8] == 4'b1000) |-> obs_data == hr_out1);

  p_early_rst_r5: assert property (@(posedge hr_clk) disable iff (!rst_n)
    (since == 3 && !rd_data[1]) |-> dl_reset == $past(cap_evt));

  p_late_rst_r6: assert property (@(posedge hr_clk) disable iff (!rst_n)
    (since == 3 && rd_data[1]) |-> dl_reset == $past(cap_evt, 2));

  p_sw_pass_r2: assert property (@(posedge hr_clk) disable iff (!rst_n)
    (rd_data[5:4] == 2'b01 && rd_data[0]) |-> cap_in == rd_data[2]);
endmodule

bind capcal_src_ctrl capcal_src_ctrl_chk #(.N_IN(N_IN), .SEL_W(SEL_W), .OBS_W(OBS_W)) u_chk (
  .hr_clk   (hr_clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .cap_evt  (cap_evt),
  .hr_out1  (hr_out1),
  .cap_in   (cap_in),
  .dl_reset (dl_reset),
  .obs_data (obs_data)
);

// File: tb/capcal_src_ctrl_tb.sv
`timescale 1ns/1ps
module capcal_src_ctrl_tb;
  logic        hr_clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [127:0] ext_in;
  logic [6:0]  ext_sel;
  logic        cap_evt;
  logic [15:0] hr_out1, hr_out2, dl1_obs1, dl2_obs1, dl1_obs2, dl2_obs2;
  logic        cap_in, dl_reset;
  logic [15:0] obs_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 hr_clk = ~hr_clk;

  capcal_src_ctrl u_dut (
    .hr_clk(hr_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ext_in(ext_in), .ext_sel(ext_sel), .cap_evt(cap_evt),
    .hr_out1(hr_out1), .hr_out2(hr_out2), .dl1_obs1(dl1_obs1), .dl2_obs1(dl2_obs1),
    .dl1_obs2(dl1_obs2), .dl2_obs2(dl2_obs2),
    .cap_in(cap_in), .dl_reset(dl_reset), .obs_data(obs_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input logic [31:0] d);
    @(posedge hr_clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge hr_clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wave_test(input bit late);
    logic a, b, prev_a, prev_b;
    int run;
    bit seen;
    prev_a = 0; prev_b = 0; run = 0; seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge hr_clk); #1;
      a = cap_in;
      if (late && i > 0) check("R4 stable across rising edge", {31'd0, a}, {31'd0, prev_b});
      #2.5;
      b = cap_in;
      if (!late) check("R3 stable across falling edge", {31'd0, b}, {31'd0, a});
      if (i == 0) run = 1;
      else if ((late ? b : a) != (late ? prev_b : prev_a)) begin
        if (seen) check(late ? "R4 run length" : "R3 run length", run, 8);
        seen = 1; run = 1;
      end else run++;
      prev_a = a; prev_b = b;
    end
    check(late ? "R4 wave toggles" : "R3 wave toggles", {31'd0, seen}, 32'd1);
  endtask

  task automatic rst_test(input bit late);
    @(posedge hr_clk); #1;
    cap_evt = 1'b1;
    @(posedge hr_clk); #1;
    cap_evt = 1'b0;
    check(late ? "R6 low before" : "R5 low before", {31'd0, dl_reset}, 0);
    #2.5;
    check(late ? "R6 after first fall" : "R5 after first fall", {31'd0, dl_reset}, {31'd0, !late});
    @(posedge hr_clk); #1;
    check(late ? "R6 mid" : "R5 mid", {31'd0, dl_reset}, {31'd0, !late});
    #2.5;
    check(late ? "R6 after second fall" : "R5 after second fall", {31'd0, dl_reset}, {31'd0, late});
    @(posedge hr_clk); #3.5;
    check(late ? "R6 end" : "R5 end", {31'd0, dl_reset}, 0);
  endtask

  function automatic logic [15:0] exp_obs(input logic [3:0] c);
    case (c)
      4'd8:  return 16'h1111;
      4'd9:  return 16'h2222;
      4'd10: return 16'h3333;
      4'd11: return 16'h4444;
      4'd12: return 16'h5555;
      4'd13: return 16'h6666;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    rst_n = 0; wr_en = 0; wr_data = 0; ext_in = '0; ext_sel = 0; cap_evt = 0;
    hr_out1 = 16'h1111; hr_out2 = 16'h2222; dl1_obs1 = 16'h3333;
    dl2_obs1 = 16'h4444; dl1_obs2 = 16'h5555; dl2_obs2 = 16'h6666;
    repeat (4) @(posedge hr_clk);
    #1 rst_n = 1;
    repeat (4) @(posedge hr_clk);
    #1;
    check("R12 fields zero", rd_data, 0);
    check("R12 reset pulse low", {31'd0, dl_reset}, 0);

    // R11 register layout
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5; pats[2] = 32'h5A5A_5A5A; pats[3] = 32'h0000_0000;
    for (int i = 0; i < 4; i++) begin
      write_cfg(pats[i]);
      check("R11 readback", rd_data, pats[i] & 32'h0000_0F37);
    end

    // R1 external sweep, pass-through
    write_cfg(32'h0000_0001);
    for (int i = 0; i < 128; i++) begin
      ext_sel = 7'(i);
      ext_in = 128'd1 << i; #0.5;
      check("R1 selected high", {31'd0, cap_in}, 1);
      ext_in = ~(128'd1 << i); #0.5;
      check("R1 selected low", {31'd0, cap_in}, 0);
    end
    ext_in = '0;

    // R8 no inversion: held source stays high
    ext_sel = 7'd5; ext_in[5] = 1'b1;
    repeat (3) @(posedge hr_clk);
    #1 check("R8 held high", {31'd0, cap_in}, 1);
    ext_in = '0;
    @(posedge hr_clk); #1;

    // R2 software bit
    write_cfg(32'h0000_0015);
    check("R2 sw high", {31'd0, cap_in}, 1);
    write_cfg(32'h0000_0011);
    check("R2 sw low", {31'd0, cap_in}, 0);

    // R3 / R4 waves
    write_cfg(32'h0000_0021);
    wave_test(0);
    write_cfg(32'h0000_0031);
    wave_test(1);

    // R7 inversion state machine on external source
    write_cfg(32'h0000_0000);
    ext_sel = 7'd77; ext_in = '0;
    repeat (2) @(posedge hr_clk);
    #1 check("R7 idle low", {31'd0, cap_in}, 0);
    for (int k = 0; k < 4; k++) begin
      ext_in[77] = ~ext_in[77]; #0.5;
      check("R7 edge pulse high", {31'd0, cap_in}, 1);
      @(posedge hr_clk); #1;
      check("R7 back low", {31'd0, cap_in}, 0);
      repeat (2) @(posedge hr_clk);
      #1 check("R7 stays low", {31'd0, cap_in}, 0);
    end
    ext_in = '0;

    // R5 / R6 reset timing
    write_cfg(32'h0000_0000);
    rst_test(0);
    write_cfg(32'h0000_0002);
    rst_test(1);

    // R9 / R10 observe sweep
    for (int c = 0; c < 16; c++) begin
      write_cfg(32'(c) << 8);
      check((c >= 8 && c <= 13) ? "R9 observe map" : "R10 observe zero",
            {16'd0, obs_data}, {16'd0, exp_obs(4'(c))});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule